// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block tracks four receive frame slots that pass between a frame receiver and software. They pass one at a time and always in the same circular order. When the receiver finishes a frame, it reports the frame length and a CRC-error flag. The block stores both for the slot at the current fill position and then moves the fill position on. Software sees only the oldest waiting slot, through one shared control word. That word shows whether the slot holds a frame, whether the frame had a CRC error, and how long it is.

Software gives the oldest slot back by writing the self-clearing release bit. The view then moves to the next slot. This is done the same way for a frame that was used and for a frame that was discarded after a CRC error. A frame that arrives while all four slots are waiting is dropped, and a saturating counter records it. The receive interrupt is a level output. The block handles slot indices and handshakes only. The byte storage and the receive datapath sit outside it.

Top module: `rx_pingpong_mgr`

## Requirements
- R1: After reset the control word reads 0, both slot indices are 0, the drop count is 0 and the interrupt is low.
- R2: While receive is enabled and fewer than four frames wait, a `fill_valid_i` pulse stores length and CRC flag in slot `fill_idx_o`. The pulse then advances `fill_idx_o` by one, modulo 4.
- R3: Bit 8 of the control word reads 1 while at least one frame waits. Bit 9 is then the CRC flag of the oldest frame and bits 26:16 are its length. With no frame waiting, bits 9 and 26:16 read 0.
- R4: While control bit 1 (receive enable) is 0, `fill_valid_i` has no effect. Nothing is stored and the drop count does not change.
- R5: A control write with bit 4 set, made while a frame waits, retires the oldest frame and advances `rd_idx_o` by one, modulo 4. Bit 4 always reads back 0.
- R6: A control write with bit 4 set while no frame waits leaves `rd_idx_o` and the waiting count unchanged.
- R7: A frame offered while four frames already wait is dropped. The stored frames and `fill_idx_o` are unchanged, and `drop_cnt_o` increments, saturating at its maximum.
- R8: `rx_irq_o` equals control bit 8 AND control bit 5 (receive interrupt enable).
- R9: A control write of zero empties all slots, returns both indices to 0 and clears both enables. A frame offered in the same cycle is ignored.
- R10: Any non-zero control write loads bits 1 and 5 from the written value. A release and a frame arriving in the same cycle both take effect. Fullness is judged on the state before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_rdata_o | output | 32 | Control word read value |
| fill_valid_i | input | 1 | Receiver reports one finished frame |
| fill_len_i | input | 11 | Length of the finished frame |
| fill_crc_err_i | input | 1 | CRC error flag of the finished frame |
| fill_ready_o | output | 1 | Receive enabled and a free slot exists |
| fill_idx_o | output | 2 | Slot the receiver fills next |
| rd_idx_o | output | 2 | Slot presented to software |
| drop_cnt_o | output | 8 | Saturating count of frames dropped while full |
| rx_irq_o | output | 1 | Level receive interrupt |

## Verification
The assertions assume that `fill_valid_i` is a single-cycle strobe per frame. They also assume that control writes are single-cycle strobes, and that a frame's length and CRC flag are valid in the strobe cycle. The bench drives every strobe for exactly one cycle at a falling edge and removes it at the next falling edge, so every edge sees at most one event of each kind. It sweeps fill depths from one to four across repeated wraps of both indices, alternating CRC flags and arithmetic lengths. It also covers same-cycle release and fill, flush with a pending frame, disabled receive, and drop-counter saturation.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int unsigned LEN_W       = 11;
  localparam int unsigned CTL_RX_EN   = 1;
  localparam int unsigned CTL_RELEASE = 4;
  localparam int unsigned CTL_IRQ_EN  = 5;
  localparam int unsigned CTL_DONE    = 8;
  localparam int unsigned CTL_CRC     = 9;
  localparam int unsigned CTL_LEN_LSB = 16;

  typedef struct packed {
    logic             crc_err;
    logic [LEN_W-1:0] len;
  } slot_info_t;
endpackage

// File: rtl/rxpp_ctrl_decode.sv
module rxpp_ctrl_decode (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic        flush_o,
  output logic        release_o,
  output logic        rx_en_o,
  output logic        irq_en_o
);
  import rxpp_pkg::*;

  assign flush_o   = we_i && (wdata_i == '0);
  assign release_o = we_i && wdata_i[CTL_RELEASE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o  <= 1'b0;
      irq_en_o <= 1'b0;
    end else if (we_i) begin
      rx_en_o  <= wdata_i[CTL_RX_EN];
      irq_en_o <= wdata_i[CTL_IRQ_EN];
    end
  end
endmodule

// File: rtl/rxpp_ring.sv
module rxpp_ring #(
  parameter int unsigned NUM_BUFS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_BUFS),
  localparam int unsigned CNT_W = $clog2(NUM_BUFS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             accept_o,
  output logic             drop_o,
  output logic             full_o,
  output logic             nonempty_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUFS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok;

  assign full_o     = (cnt_q == CNT_W'(NUM_BUFS));
  assign nonempty_o = (cnt_q != '0);
  assign accept_o   = push_i && !full_o && !flush_i;
  assign drop_o     = push_i && full_o && !flush_i;
  assign pop_ok     = pop_i && nonempty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_idx_o <= '0;
      rd_idx_o <= '0;
    end else if (flush_i) begin
      cnt_q    <= '0;
      wr_idx_o <= '0;
      rd_idx_o <= '0;
    end else begin
      if (accept_o) wr_idx_o <= (wr_idx_o == LAST) ? '0 : wr_idx_o + 1'b1;
      if (pop_ok)   rd_idx_o <= (rd_idx_o == LAST) ? '0 : rd_idx_o + 1'b1;
      cnt_q <= cnt_q + CNT_W'(accept_o) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/rxpp_slot_store.sv
module rxpp_slot_store #(
  parameter int unsigned NUM_BUFS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_BUFS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     widx_i,
  input  rxpp_pkg::slot_info_t winfo_i,
  input  logic [IDX_W-1:0]     ridx_i,
  output rxpp_pkg::slot_info_t rinfo_o
);
  rxpp_pkg::slot_info_t slot_q [NUM_BUFS];

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))      slot_q[g] <= winfo_i;
    end
  end

  assign rinfo_o = slot_q[ridx_i];
endmodule

// File: rtl/rx_pingpong_mgr.sv
module rx_pingpong_mgr #(
  parameter int unsigned NUM_BUFS = 4,
  parameter int unsigned DROP_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_BUFS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ctrl_we_i,
  input  logic [31:0]                ctrl_wdata_i,
  output logic [31:0]                ctrl_rdata_o,
  input  logic                       fill_valid_i,
  input  logic [rxpp_pkg::LEN_W-1:0] fill_len_i,
  input  logic                       fill_crc_err_i,
  output logic                       fill_ready_o,
  output logic [IDX_W-1:0]           fill_idx_o,
  output logic [IDX_W-1:0]           rd_idx_o,
  output logic [DROP_W-1:0]          drop_cnt_o,
  output logic                       rx_irq_o
);
  import rxpp_pkg::*;

  logic flush, release_req, rx_en, irq_en;
  logic accept, drop, full, nonempty;
  slot_info_t winfo, rinfo;

  rxpp_ctrl_decode i_ctrl (
    .clk_i, .rst_ni,
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .flush_o   (flush),
    .release_o (release_req),
    .rx_en_o   (rx_en),
    .irq_en_o  (irq_en)
  );

  rxpp_ring #(.NUM_BUFS(NUM_BUFS)) i_ring (
    .clk_i, .rst_ni,
    .flush_i    (flush),
    .push_i     (fill_valid_i && rx_en),
    .pop_i      (release_req),
    .accept_o   (accept),
    .drop_o     (drop),
    .full_o     (full),
    .nonempty_o (nonempty),
    .wr_idx_o   (fill_idx_o),
    .rd_idx_o   (rd_idx_o)
  );

  assign winfo = '{crc_err: fill_crc_err_i, len: fill_len_i};

  rxpp_slot_store #(.NUM_BUFS(NUM_BUFS)) i_store (
    .clk_i, .rst_ni,
    .we_i    (accept),
    .widx_i  (fill_idx_o),
    .winfo_i (winfo),
    .ridx_i  (rd_idx_o),
    .rinfo_o (rinfo)
  );

  // saturating drop counter, kept across flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      drop_cnt_o <= '0;
    else if (drop && !(&drop_cnt_o))  drop_cnt_o <= drop_cnt_o + 1'b1;
  end

  always_comb begin
    ctrl_rdata_o             = '0;
    ctrl_rdata_o[CTL_RX_EN]  = rx_en;
    ctrl_rdata_o[CTL_IRQ_EN] = irq_en;
    ctrl_rdata_o[CTL_DONE]   = nonempty;
    if (nonempty) begin
      ctrl_rdata_o[CTL_CRC]                  = rinfo.crc_err;
      ctrl_rdata_o[CTL_LEN_LSB +: LEN_W]     = rinfo.len;
    end
  end

  assign fill_ready_o = rx_en && !full;
  assign rx_irq_o     = nonempty && irq_en;
endmodule

// File: rtl/rxpp_checker.sv
module rxpp_checker #(
  parameter int unsigned NUM_BUFS = 4,
  parameter int unsigned DROP_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_BUFS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [31:0]       ctrl_wdata_i,
  input logic [31:0]       ctrl_rdata_o,
  input logic              fill_valid_i,
  input logic              fill_ready_o,
  input logic [IDX_W-1:0]  fill_idx_o,
  input logic [IDX_W-1:0]  rd_idx_o,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic              rx_irq_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUFS - 1);

  logic             flush;
  logic [IDX_W-1:0] rd_next, fill_next;
  logic [DROP_W-1:0] drop_next;

  assign flush     = ctrl_we_i && (ctrl_wdata_i == '0);
  assign rd_next   = (rd_idx_o == LAST) ? '0 : rd_idx_o + 1'b1;
  assign fill_next = (fill_idx_o == LAST) ? '0 : fill_idx_o + 1'b1;
  assign drop_next = (&drop_cnt_o) ? drop_cnt_o : drop_cnt_o + 1'b1;

  a_r2_accept_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && fill_ready_o && !flush |=> fill_idx_o == $past(fill_next) && ctrl_rdata_o[8]);

  a_r4_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && !ctrl_rdata_o[1] && !flush |=> $stable(fill_idx_o) && $stable(drop_cnt_o));

  a_r5_release_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[4]);

  a_r5_release_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[4] && ctrl_rdata_o[8] |=> rd_idx_o == $past(rd_next));

  a_r6_empty_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[4] && !ctrl_rdata_o[8] |=> $stable(rd_idx_o));

  a_r7_drop_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && ctrl_rdata_o[1] && !fill_ready_o && !flush
    |=> drop_cnt_o == $past(drop_next) && $stable(fill_idx_o));

  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o == (ctrl_rdata_o[8] && ctrl_rdata_o[5]));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> rd_idx_o == '0 && fill_idx_o == '0 && !ctrl_rdata_o[8] && !ctrl_rdata_o[1]);
endmodule

bind rx_pingpong_mgr rxpp_checker #(.NUM_BUFS(NUM_BUFS), .DROP_W(DROP_W)) i_rxpp_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .fill_valid_i (fill_valid_i),
  .fill_ready_o (fill_ready_o),
  .fill_idx_o   (fill_idx_o),
  .rd_idx_o     (rd_idx_o),
  .drop_cnt_o   (drop_cnt_o),
  .rx_irq_o     (rx_irq_o)
);

// File: tb/test_rx_pingpong_mgr.sv
`timescale 1ns/1ps
module test_rx_pingpong_mgr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] ctrl_rdata_o;
  logic        fill_valid_i = 1'b0;
  logic [10:0] fill_len_i = '0;
  logic        fill_crc_err_i = 1'b0;
  logic        fill_ready_o;
  logic [1:0]  fill_idx_o, rd_idx_o;
  logic [7:0]  drop_cnt_o;
  logic        rx_irq_o;

  int checks = 0;
  int failures = 0;

  // bench model
  int m_cnt = 0, m_rd = 0, m_wr = 0, m_drop = 0;
  bit m_en = 0, m_ie = 0;
  int m_len [4] = '{0, 0, 0, 0};
  bit m_crc [4] = '{0, 0, 0, 0};

  always #10 clk_i = ~clk_i;

  rx_pingpong_mgr i_rx_pingpong_mgr (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .ctrl_rdata_o,
    .fill_valid_i, .fill_len_i, .fill_crc_err_i, .fill_ready_o,
    .fill_idx_o, .rd_idx_o, .drop_cnt_o, .rx_irq_o
  );

  task automatic chk(input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [31:0] exp_word;
    exp_word = '0;
    exp_word[1] = m_en;
    exp_word[5] = m_ie;
    if (m_cnt > 0) begin
      exp_word[8] = 1'b1;
      exp_word[9] = m_crc[m_rd];
      exp_word[26:16] = 11'(m_len[m_rd]);
    end
    chk(ctrl_rdata_o, exp_word, {req, " control word"});
    chk(rd_idx_o, m_rd, {req, " rd_idx"});
    chk(fill_idx_o, m_wr, {req, " fill_idx"});
    chk(drop_cnt_o, m_drop, {req, " drop_cnt R7"});
    chk(rx_irq_o, (m_cnt > 0) && m_ie, {req, " irq R8"});
    chk(fill_ready_o, m_en && (m_cnt < 4), {req, " fill_ready"});
  endtask

  task automatic step(input bit we, input logic [31:0] wd, input bit fv,
                      input int len, input bit crc, input string req);
    bit flush, rel, acc, drp;
    @(negedge clk_i);
    ctrl_we_i = we; ctrl_wdata_i = wd;
    fill_valid_i = fv; fill_len_i = 11'(len); fill_crc_err_i = crc;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0; fill_valid_i = 1'b0;
    flush = we && (wd == 0);
    rel   = we && wd[4] && (m_cnt > 0) && !flush;
    acc   = fv && m_en && (m_cnt < 4) && !flush;
    drp   = fv && m_en && (m_cnt == 4) && !flush;
    if (flush) begin
      m_cnt = 0; m_rd = 0; m_wr = 0; m_en = 0; m_ie = 0;
    end else begin
      if (acc) begin
        m_len[m_wr] = len % 2048;
        m_crc[m_wr] = crc;
        m_wr = (m_wr + 1) % 4;
      end
      if (rel) m_rd = (m_rd + 1) % 4;
      m_cnt = m_cnt + int'(acc) - int'(rel);
      if (drp && m_drop < 255) m_drop++;
      if (we) begin m_en = wd[1]; m_ie = wd[5]; end
    end
    check_all(req);
  endtask

  task automatic frame(input int len, input bit crc, input string req);
    step(1'b0, '0, 1'b1, len, crc, req);
  endtask

  task automatic wr(input logic [31:0] wd, input string req);
    step(1'b1, wd, 1'b0, 0, 1'b0, req);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_all("R1 before reset release");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // R4: receive disabled, interrupt enabled
    wr(32'h20, "R10");
    frame(100, 1'b1, "R4");
    frame(200, 1'b0, "R4");
    wr(32'h22, "R10");
    wr(32'h32, "R6");

    // R2 R3 R5 R6 R7: depth sweep across index wraps
    for (int r = 0; r < 12; r++) begin
      int n = (r % 4) + 1;
      for (int i = 0; i < n; i++)
        frame((r * 97 + i * 211 + 60) % 2048, 1'((r + i) & 1), "R2 R3");
      if (n == 4) begin
        frame(1234, 1'b1, "R7");
        frame(77, 1'b0, "R7");
      end
      for (int i = 0; i < n; i++)
        wr((r % 2) ? 32'h12 : 32'h32, "R5 R8");
      wr(32'h32, "R6");
    end

    // R10: release and fill in same cycle
    for (int i = 0; i < 4; i++) frame(300 + i, 1'(i), "R2");
    step(1'b1, 32'h32, 1'b1, 999, 1'b1, "R10 full before release");
    step(1'b1, 32'h32, 1'b1, 555, 1'b0, "R10 both act");
    for (int i = 0; i < 4; i++) wr(32'h32, "R5");

    // R9: flush with pending frames and a frame in the same cycle
    frame(40, 1'b1, "R2");
    frame(41, 1'b0, "R2");
    step(1'b1, 32'h0, 1'b1, 42, 1'b1, "R9");
    frame(43, 1'b0, "R9 disabled after flush");
    wr(32'h22, "R10");
    frame(44, 1'b1, "R9 restart at slot 0");
    wr(32'h32, "R5");

    // R7: saturation of drop counter
    for (int i = 0; i < 4; i++) frame(500 + i * 3, 1'b0, "R2");
    for (int i = 0; i < 260; i++) frame(i, 1'b1, "R7 saturate");
    for (int i = 0; i < 4; i++) wr(32'h32, "R5");
    wr(32'h0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule